// File: doc/BRIEF.md
# DDR Command Spacing Timer

This block sits beside the command scheduler of a DDR SDRAM controller and decides, every clock, whether the command the scheduler proposes may go out now. It watches three gaps that follow a WRITE. The first is a READ to the same bank and row as that write. The second is a READ to any other row or bank. The third is a PRECHARGE to a bank that was written. Each gap is counted in controller clocks from the cycle in which the WRITE was issued.

The minimum gaps come from encoded fields of a 32-bit timing register, which is written and read back over a plain register port. A 2-bit code sets the gap for a read to a different row. A 1-bit code sets the write-recovery gap. A third 1-bit code sets the gap for a read to the same row, and that code has a single legal value. Reserved codes fall back to the safest legal gap. The scheduler drives `cmd_valid` with its proposal. A command counts as issued only in a cycle where `cmd_valid` and `issue_ok` are both high, and only issued commands move the timers.

Top module: `ddr_cmd_spacer`

## Requirements
- R1: After reset, `reg_rdata` reads 0x18004425. In that state the read-to-other-row gap is 3 clocks, the write-recovery gap is 2 clocks and the same-row read gap is 1 clock.
- R2: A cycle with `reg_wr_en` high loads `reg_wdata`. From the next clock the new value reads back on `reg_rdata`, and the gaps decoded from it govern `issue_ok`.
- R3: Command codes on `cmd_type` are 00 none, 01 READ, 10 WRITE and 11 PRECHARGE. `issue_ok` is always high for none and for WRITE.
- R4: A READ whose bank and row equal those of the most recent issued WRITE is allowed 1 clock or more after that write. Bit 31 set to 0 gives 1 clock. Its reserved value 1 also gives 1 clock.
- R5: Any other READ is allowed once the gap since the most recent issued WRITE reaches the value of bits 29:28. The codes map as 00 = 4, 01 = 3, 10 = 2 and 11 (reserved) = 4 clocks.
- R6: A PRECHARGE to bank b is allowed once the gap since the last issued WRITE to bank b reaches the write-recovery value. Bit 30 set to 0 gives 2 clocks and 1 gives 3 clocks. Writes to other banks have no effect on it.
- R7: The elapsed counters saturate at 4. After reset, and after 4 or more idle clocks following a write, every command is allowed.
- R8: A WRITE that is proposed with `cmd_valid` low is not counted, so it does not delay a later READ or PRECHARGE.
- R9: A counter that is already running is compared against the new gaps as soon as a register write takes effect. The gap is still measured from the original WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Load the timing register this cycle |
| reg_wdata | input | 32 | Value to load into the timing register |
| reg_rdata | output | 32 | Current timing register contents |
| cmd_valid | input | 1 | Scheduler wants to issue the proposed command |
| cmd_type | input | 2 | Proposed command: 00 none, 01 READ, 10 WRITE, 11 PRECHARGE |
| cmd_bank | input | BANK_W (2) | Bank of the proposed command |
| cmd_row | input | ROW_W (13) | Row of the proposed command |
| issue_ok | output | 1 | Proposed command meets every spacing rule this cycle |

## Verification
The hardest case to reach is a register rewrite while a write-to-read counter is partway through its count, because the gap must then switch limits without restarting. The bench sets the longest code, issues a write, rewrites the register one clock later with a shorter code, and holds a different-row read proposal until it is granted. A behavioural model keeps absolute issue times instead of counters and predicts `issue_ok` on every clock. That model runs through all sixteen combinations of the three fields and then a long random phase of mixed commands.

// File: rtl/ddr_spacer_pkg.sv
package ddr_spacer_pkg;
   typedef enum logic [1:0] {
      CMD_NONE = 2'b00,
      CMD_RD   = 2'b01,
      CMD_WR   = 2'b10,
      CMD_PRE  = 2'b11
   } cmd_e;

   // longest spacing any field can select
   localparam int LIM_MAX = 4;
   localparam int LIM_W   = $clog2(LIM_MAX + 1);

   typedef struct packed {
      logic [LIM_W-1:0] rd_same;
      logic [LIM_W-1:0] rd_diff;
      logic [LIM_W-1:0] wr_rec;
   } lim_t;
endpackage

// File: rtl/spc_cfg_reg.sv
module spc_cfg_reg
   import ddr_spacer_pkg::*;
#(
   parameter logic [31:0] RESET_VAL = 32'h1800_4425,
   parameter int          SAME_BIT  = 31,
   parameter int          REC_BIT   = 30,
   parameter int          DIFF_LSB  = 28
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] q,
   output lim_t        lim
);
   if (DIFF_LSB > 30 || SAME_BIT > 31 || REC_BIT > 31) begin : g_bad_field
      $error("spc_cfg_reg: field position out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= RESET_VAL;
      else if (wr_en) q <= wdata;
   end

   logic [1:0] diff_code;
   assign diff_code = q[DIFF_LSB +: 2];

   always_comb begin
      // same-row gap: only legal setting is one clock, reserved maps to it
      lim.rd_same = LIM_W'(1);
      lim.wr_rec  = q[REC_BIT] ? LIM_W'(3) : LIM_W'(2);
      unique case (diff_code)
         2'b01:   lim.rd_diff = LIM_W'(3);
         2'b10:   lim.rd_diff = LIM_W'(2);
         default: lim.rd_diff = LIM_W'(LIM_MAX); // 00 and reserved 11
      endcase
   end

   // R2
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> q == $past(wdata));
endmodule

// File: rtl/spc_wr_tracker.sv
module spc_wr_tracker
   import ddr_spacer_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 13
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [ROW_W-1:0]  rd_row,
   output logic              same_hit,
   output logic [LIM_W-1:0]  elapsed
);
   logic [BANK_W-1:0] last_bank;
   logic [ROW_W-1:0]  last_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_bank <= '0;
         last_row  <= '0;
         elapsed   <= LIM_W'(LIM_MAX);
      end else if (wr_fire) begin
         last_bank <= wr_bank;
         last_row  <= wr_row;
         elapsed   <= LIM_W'(1);
      end else if (elapsed < LIM_W'(LIM_MAX)) begin
         elapsed   <= elapsed + LIM_W'(1);
      end
   end

   assign same_hit = (rd_bank == last_bank) && (rd_row == last_row);

   // R5
   trk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> elapsed == LIM_W'(1));
   // R7
   trk_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elapsed <= LIM_W'(LIM_MAX));
endmodule

// File: rtl/spc_bank_timer.sv
module spc_bank_timer
   import ddr_spacer_pkg::*;
#(
   parameter int BANKS  = 4,
   parameter int BANK_W = $clog2(BANKS)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_fire,
   input  logic [BANK_W-1:0]             wr_bank,
   output logic [BANKS-1:0][LIM_W-1:0]   elapsed
);
   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic hit;
      assign hit = wr_fire && (wr_bank == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n)                               elapsed[b] <= LIM_W'(LIM_MAX);
         else if (hit)                             elapsed[b] <= LIM_W'(1);
         else if (elapsed[b] < LIM_W'(LIM_MAX))    elapsed[b] <= elapsed[b] + LIM_W'(1);
      end

      // R6
      bank_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_fire && !hit && elapsed[b] < LIM_W'(LIM_MAX)) |=>
            elapsed[b] == $past(elapsed[b]) + LIM_W'(1));
   end
endmodule

// File: rtl/ddr_cmd_spacer.sv
module ddr_cmd_spacer
   import ddr_spacer_pkg::*;
#(
   parameter int          BANKS     = 4,
   parameter int          ROW_W     = 13,
   parameter logic [31:0] RESET_VAL = 32'h1800_4425,
   localparam int         BANK_W    = $clog2(BANKS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_type,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_W-1:0]  cmd_row,
   output logic              issue_ok
);
   if (BANKS < 2 || BANKS != (1 << BANK_W)) begin : g_bad_banks
      $error("ddr_cmd_spacer: BANKS must be a power of two, at least 2");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ddr_cmd_spacer: ROW_W must be positive");
   end

   lim_t                        lim;
   logic                        same_hit;
   logic [LIM_W-1:0]            wr_elapsed;
   logic [BANKS-1:0][LIM_W-1:0] bank_elapsed;
   cmd_e                        cmd;
   logic                        fire, wr_fire;

   assign cmd     = cmd_e'(cmd_type);
   assign fire    = cmd_valid && issue_ok;
   assign wr_fire = fire && (cmd == CMD_WR);

   spc_cfg_reg #(.RESET_VAL(RESET_VAL)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .q(reg_rdata), .lim(lim));

   spc_wr_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) trk_i (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_bank(cmd_bank),
      .wr_row(cmd_row), .rd_bank(cmd_bank), .rd_row(cmd_row),
      .same_hit(same_hit), .elapsed(wr_elapsed));

   spc_bank_timer #(.BANKS(BANKS), .BANK_W(BANK_W)) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_bank(cmd_bank),
      .elapsed(bank_elapsed));

   always_comb begin
      unique case (cmd)
         CMD_RD:  issue_ok = wr_elapsed >= (same_hit ? lim.rd_same : lim.rd_diff);
         CMD_PRE: issue_ok = bank_elapsed[cmd_bank] >= lim.wr_rec;
         default: issue_ok = 1'b1;
      endcase
   end

   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R5
   rd_diff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && fire && cmd == CMD_RD && !same_hit) |-> !$past(wr_fire));
   // R6
   pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && fire && cmd == CMD_PRE) |->
         !($past(wr_fire) && $past(cmd_bank) == cmd_bank));
   // R3
   wr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WR || cmd == CMD_NONE) |-> issue_ok);
endmodule

// File: tb/ddr_cmd_spacer_tb.sv
module ddr_cmd_spacer_tb_top;
   localparam int BANKS = 4;
   localparam int BW    = 2;
   localparam int RW    = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_type = 2'b00;
   logic [BW-1:0] cmd_bank = '0;
   logic [RW-1:0] cmd_row = '0;
   logic          issue_ok;

   always #4 clk = ~clk; // 125 MHz

   ddr_cmd_spacer #(.BANKS(BANKS), .ROW_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .issue_ok(issue_ok));

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   // behavioural model: absolute issue times
   int          wr_t = -100;
   int          wr_b = 0;
   int          wr_r = 0;
   int          bank_t[BANKS];
   logic [31:0] mreg = 32'h1800_4425;

   function automatic int diff_gap(logic [31:0] r);
      case (r[29:28])
         2'b01:   return 3;
         2'b10:   return 2;
         default: return 4;
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [1:0] t, input int b, input int r,
                       input bit rw, input logic [31:0] wd, input string tag,
                       output bit fired);
      bit    exp;
      string req;
      cmd_valid = v; cmd_type = t; cmd_bank = BW'(b); cmd_row = RW'(r);
      reg_wr_en = rw; reg_wdata = wd;
      #1;
      case (t)
         2'b01: begin
            if (b == wr_b && r == wr_r) begin exp = (cyc - wr_t) >= 1; req = "R4"; end
            else begin exp = (cyc - wr_t) >= diff_gap(mreg); req = "R5"; end
         end
         2'b11: begin
            exp = (cyc - bank_t[b]) >= (mreg[30] ? 3 : 2); req = "R6";
         end
         default: begin exp = 1'b1; req = "R3"; end
      endcase
      check(issue_ok == exp, {req, "/", tag}, "issue_ok", issue_ok, exp);
      check(reg_rdata == mreg, {"R2/", tag}, "reg_rdata", reg_rdata, mreg);
      fired = v && exp;
      @(posedge clk);
      cyc++;
      if (fired && t == 2'b10) begin wr_t = cyc - 1; wr_b = b; wr_r = r; bank_t[b] = cyc - 1; end
      if (rw) mreg = wd;
      @(negedge clk);
   endtask

   task automatic cmd(input logic [1:0] t, input int b, input int r, input string tag);
      bit f;
      step(1'b1, t, b, r, 1'b0, '0, tag, f);
   endtask

   task automatic until_ok(input logic [1:0] t, input int b, input int r, input string tag);
      bit f = 1'b0;
      for (int i = 0; i < 8 && !f; i++) step(1'b1, t, b, r, 1'b0, '0, tag, f);
      check(f, tag, "never issued", 0, 1);
   endtask

   task automatic wreg(input logic [31:0] v, input string tag);
      bit f;
      step(1'b0, 2'b00, 0, 0, 1'b1, v, tag, f);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", "timeout", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit f;
      foreach (bank_t[i]) bank_t[i] = -100;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset value and reset gaps
      check(reg_rdata == 32'h1800_4425, "R1", "reset reg", reg_rdata, 32'h1800_4425);
      cmd(2'b10, 1, 5, "R1"); until_ok(2'b01, 2, 5, "R1");
      cmd(2'b10, 0, 5, "R1"); until_ok(2'b11, 0, 5, "R1");

      // every field combination
      for (int c = 0; c < 16; c++) begin
         logic [31:0] v;
         v = 32'h1800_4425;
         v[31] = c[3]; v[30] = c[2]; v[29:28] = c[1:0];
         wreg(v, "R2");
         cmd(2'b10, 1, 5, "R3");
         until_ok(2'b01, 2, 5, "R5");
         cmd(2'b10, 1, 5, "R3");
         until_ok(2'b01, 1, 5, "R4");
         cmd(2'b10, 1, 7, "R3");
         until_ok(2'b01, 1, 8, "R5");
         cmd(2'b10, 0, 3, "R3");
         cmd(2'b11, 3, 0, "R6");
         until_ok(2'b11, 0, 0, "R6");
         for (int i = 0; i < 5; i++) cmd(2'b00, 0, 0, "R7");
         cmd(2'b01, 3, 99, "R7");
         cmd(2'b11, 1, 0, "R7");
      end

      // R8: write proposed without valid is not counted
      for (int i = 0; i < 5; i++) cmd(2'b00, 0, 0, "R8");
      step(1'b0, 2'b10, 2, 4, 1'b0, '0, "R8", f);
      cmd(2'b01, 3, 9, "R8");
      cmd(2'b11, 2, 0, "R8");

      // R9: limit shrinks while counter runs
      wreg(32'h0800_4425 & 32'h8FFF_FFFF, "R9");
      cmd(2'b10, 0, 1, "R9");
      wreg(32'h2000_4425, "R9");
      until_ok(2'b01, 3, 3, "R9");
      cmd(2'b10, 0, 1, "R9");
      wreg(32'h0000_4425, "R9");
      until_ok(2'b01, 3, 3, "R9");

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] v;
         v = $urandom;
         step(($urandom % 4) != 0, 2'($urandom), $urandom % BANKS, $urandom % 3,
              ($urandom % 16) == 0, v, "rand", f);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule